// File: doc/BRIEF.md
# Indexed Colour Palette DAC

This block is a 256-entry colour lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue field. Software reaches the table through a small 32-bit write port. It first writes a pointer register with the entry number. It then writes one shared colour register three times, and the block steps the channel from red to green to blue. After the third write the pointer moves on to the next entry, so a run of colour writes can fill consecutive entries without touching the pointer again.

The pixel side is a valid/ready stream. An 8-bit colour index goes in and the 24-bit colour comes out on the next clock. An input beat is taken when `pix_in_valid` and `pix_in_ready` are both high. `pix_in_ready` is high when the output stage is empty, or when it is being emptied in the same cycle. While the output is valid and `pix_out_ready` is low, the output stays frozen and no new input is taken. The upstream side may hold `pix_in_valid` for as long as it needs to.

Top module: `lut_palette_dac`

## Requirements
- R1: A write with `reg_addr[3:2]` = 0 (pointer register) loads the entry pointer from `reg_wdata[31:24]` and sets the channel step to red.
- R2: A write with `reg_addr[3:2]` = 1 (colour register) stores `reg_wdata[31:24]` into one field of the entry selected by the pointer. The field is red, then green, then blue on successive writes. `reg_wdata[23:0]` has no effect.
- R3: The colour write that sets blue returns the channel step to red and advances the pointer by one. The pointer wraps from 255 to 0.
- R4: Only `reg_addr[3:2]` selects the register. All other address bits are ignored.
- R5: Writes with `reg_addr[3:2]` = 2 or 3 change neither the table, the pointer nor the channel step. `reg_rdata` is always zero.
- R6: After reset, entries 0 to 254 read as 24'h000000 and entry 255 reads as 24'hFFFFFF. The pointer is 0 and the channel step is red.
- R7: An accepted pixel index gives `pix_out_valid` high on the next clock. `pix_out_rgb` then holds {red[23:16], green[15:8], blue[7:0]} of that entry.
- R8: While `pix_out_valid` is high and `pix_out_ready` is low, `pix_in_ready` is low and `pix_out_valid` and `pix_out_rgb` hold. Palette writes made during the stall do not alter the held output.
- R9: If a pixel index is accepted in the same cycle as a colour write to that same entry, the pixel output shows the entry's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address; bits [3:2] select the register |
| reg_wdata | input | 32 | Register write data; the top byte is used |
| reg_rdata | output | 32 | Register read data, always zero |
| pix_in_valid | input | 1 | Pixel index beat offered |
| pix_in_ready | output | 1 | Pixel index beat can be taken |
| pix_in_index | input | 8 | Colour index to look up |
| pix_out_valid | output | 1 | Colour result present |
| pix_out_ready | input | 1 | Downstream takes the colour result |
| pix_out_rgb | output | 24 | Looked-up colour {R,G,B} |

## Verification
A colour write from software and a pixel lookup can land on the same entry in the same cycle. The bench provokes this by driving a colour write and a pixel beat for that entry on one clock edge. It then expects the pre-write colour on the output, and the new colour on a second lookup. A palette write made during an output stall is also checked: the frozen output must not change.

// File: rtl/lut_dac_pkg.sv
`timescale 1ns/1ps
package lut_dac_pkg;
  localparam int CH_W = 8;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] blu;
  } rgb_t;

  typedef enum logic [1:0] {
    STEP_RED = 2'd0,
    STEP_GRN = 2'd1,
    STEP_BLU = 2'd2
  } step_e;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_COL  = 2'd1,
    SEL_NOP2 = 2'd2,
    SEL_NOP3 = 2'd3
  } regsel_e;
endpackage

// File: rtl/lut_dac_regif.sv
`timescale 1ns/1ps
module lut_dac_regif
  import lut_dac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_idx,
  output step_e             tbl_step,
  output logic [CH_W-1:0]   tbl_val
);
  localparam int SEL_LSB = 2;

  regsel_e          sel;
  logic [IDX_W-1:0] ptr_q;
  step_e            step_q;
  logic             unused_bits;

  assign sel         = regsel_e'(addr[SEL_LSB+1:SEL_LSB]);
  assign unused_bits = ^{addr[ADDR_W-1:SEL_LSB+2], addr[SEL_LSB-1:0],
                         wdata[DATA_W-CH_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= STEP_RED;
    end else if (wr_en) begin
      case (sel)
        SEL_PTR: begin
          ptr_q  <= wdata[DATA_W-1 -: IDX_W];
          step_q <= STEP_RED;
        end
        SEL_COL: begin
          case (step_q)
            STEP_RED: step_q <= STEP_GRN;
            STEP_GRN: step_q <= STEP_BLU;
            default: begin
              step_q <= STEP_RED;
              ptr_q  <= ptr_q + 1'b1;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  assign tbl_we   = wr_en && (sel == SEL_COL);
  assign tbl_idx  = ptr_q;
  assign tbl_step = step_q;
  assign tbl_val  = wdata[DATA_W-1 -: CH_W];

  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PTR) |=>
      (step_q == STEP_RED && ptr_q == $past(wdata[DATA_W-1 -: IDX_W])));

  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && step_q == STEP_RED) |=> (step_q == STEP_GRN));

  // R3
  blue_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && step_q == STEP_BLU) |=>
      (step_q == STEP_RED && ptr_q == $past(ptr_q) + 1'b1));

  // R5
  dead_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_NOP2 || sel == SEL_NOP3)) |=>
      ($stable(ptr_q) && $stable(step_q)));
endmodule

// File: rtl/lut_dac_table.sv
`timescale 1ns/1ps
module lut_dac_table
  import lut_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  step_e            wstep,
  input  logic [CH_W-1:0]  wval,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output rgb_t             rdata
);
  localparam int   NUM_ENT = 1 << IDX_W;
  localparam rgb_t WHITE   = '{red: '1, grn: '1, blu: '1};

  rgb_t ents [NUM_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        ents[i] <= (i == NUM_ENT - 1) ? WHITE : '0;
      end
    end else if (we) begin
      case (wstep)
        STEP_RED: ents[widx].red <= wval;
        STEP_GRN: ents[widx].grn <= wval;
        default:  ents[widx].blu <= wval;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (re) rdata <= ents[ridx];
  end

  // R9
  old_on_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re && we && ridx == widx) |=> (rdata == $past(ents[ridx])));
endmodule

// File: rtl/lut_palette_dac.sv
`timescale 1ns/1ps
module lut_palette_dac
  import lut_dac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pix_in_valid,
  output logic              pix_in_ready,
  input  logic [IDX_W-1:0]  pix_in_index,
  output logic              pix_out_valid,
  input  logic              pix_out_ready,
  output logic [3*CH_W-1:0] pix_out_rgb
);
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_idx;
  step_e            tbl_step;
  logic [CH_W-1:0]  tbl_val;
  logic             take;
  logic             ov_q;
  rgb_t             rd_rgb;

  lut_dac_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) regif_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_step(tbl_step), .tbl_val(tbl_val)
  );

  lut_dac_table #(.IDX_W(IDX_W)) table_i (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx),
    .wstep(tbl_step), .wval(tbl_val), .re(take), .ridx(pix_in_index),
    .rdata(rd_rgb)
  );

  assign pix_in_ready = !ov_q || pix_out_ready;
  assign take         = pix_in_valid && pix_in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ov_q <= 1'b0;
    else if (take)          ov_q <= 1'b1;
    else if (pix_out_ready) ov_q <= 1'b0;
  end

  assign pix_out_valid = ov_q;
  assign pix_out_rgb   = rd_rgb;
  assign reg_rdata     = '0;

  // R7
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_in_valid && pix_in_ready) |=> pix_out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready) |=> (pix_out_valid && $stable(pix_out_rgb)));
endmodule

// File: tb/lut_palette_dac_tb.sv
`timescale 1ns/1ps
module lut_palette_dac_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_in_valid = 1'b0;
  logic        pix_in_ready;
  logic [7:0]  pix_in_index = '0;
  logic        pix_out_valid;
  logic        pix_out_ready = 1'b1;
  logic [23:0] pix_out_rgb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  lut_palette_dac dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in_valid(pix_in_valid),
    .pix_in_ready(pix_in_ready), .pix_in_index(pix_in_index),
    .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready),
    .pix_out_rgb(pix_out_rgb)
  );

  typedef struct packed {
    logic        look;
    logic [11:0] addr;
    logic [31:0] data;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h05000000, 24'h0},
    '{1'b0, 12'h004, 32'h11ABCDEF, 24'h0},
    '{1'b0, 12'h004, 32'h22000000, 24'h0},
    '{1'b0, 12'h004, 32'h33FFFFFF, 24'h0},
    '{1'b0, 12'h004, 32'h44000000, 24'h0},
    '{1'b1, 12'h005, 32'h0,        24'h112233},
    '{1'b1, 12'h006, 32'h0,        24'h440000},
    '{1'b0, 12'hF00, 32'hFE123456, 24'h0},
    '{1'b0, 12'h7F5, 32'hA0000000, 24'h0},
    '{1'b0, 12'h008, 32'h55000000, 24'h0},
    '{1'b0, 12'h00C, 32'h66000000, 24'h0},
    '{1'b0, 12'h004, 32'hB0000000, 24'h0},
    '{1'b0, 12'h004, 32'hC0000000, 24'h0},
    '{1'b0, 12'h004, 32'h01000000, 24'h0},
    '{1'b0, 12'h004, 32'h02000000, 24'h0},
    '{1'b0, 12'h004, 32'h03000000, 24'h0},
    '{1'b0, 12'h004, 32'h77000000, 24'h0},
    '{1'b1, 12'h0FE, 32'h0,        24'hA0B0C0},
    '{1'b1, 12'h0FF, 32'h0,        24'h010203},
    '{1'b1, 12'h000, 32'h0,        24'h770000}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    check("R5 rdata zero", reg_rdata, 32'h0);
  endtask

  task automatic look(string tag, logic [7:0] idx, logic [23:0] exp);
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_index = idx;
    @(negedge clk);
    pix_in_valid = 1'b0;
    check({tag, " valid"}, {31'b0, pix_out_valid}, 32'h1);
    check(tag, {8'h0, pix_out_rgb}, {8'h0, exp});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 out_valid after reset", {31'b0, pix_out_valid}, 32'h0);
    check("R8 in_ready after reset", {31'b0, pix_in_ready}, 32'h1);
    look("R6 entry 255 white", 8'hFF, 24'hFFFFFF);
    look("R6 entry 1 black", 8'h01, 24'h000000);
    look("R6 entry 128 black", 8'h80, 24'h000000);
    // R6 pointer 0 and step red: first colour write lands on red of entry 0
    wr(12'h004, 32'h0F000000);
    look("R6 reset pointer/step", 8'h00, 24'h0F0000);

    // vector walk: R1 R2 R3 R4 R5 R7
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].look) look("R7/R2/R3/R4/R5 vector", VECS[k].addr[7:0], VECS[k].exp);
      else wr(VECS[k].addr, VECS[k].data);
    end

    // R1: pointer write restarts the channel step at red
    wr(12'h000, 32'h0A000000);
    wr(12'h004, 32'h12000000);
    wr(12'h000, 32'h0A000000);
    wr(12'h004, 32'h34000000);
    look("R1 step reset by pointer write", 8'h0A, 24'h340000);

    // R8: back-pressure holds the output, blocks input
    @(negedge clk);
    pix_out_ready = 1'b0;
    pix_in_valid = 1'b1; pix_in_index = 8'h05;
    @(negedge clk);
    pix_in_index = 8'h06;
    check("R8 in_ready low in stall", {31'b0, pix_in_ready}, 32'h0);
    check("R8 stalled rgb", {8'h0, pix_out_rgb}, 32'h112233);
    reg_wr_en = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h05000000;
    @(negedge clk);
    reg_addr = 12'h004; reg_wdata = 32'h99000000;
    @(negedge clk);
    reg_wr_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 held valid", {31'b0, pix_out_valid}, 32'h1);
    check("R8 held rgb after write", {8'h0, pix_out_rgb}, 32'h112233);
    pix_out_ready = 1'b1;
    @(negedge clk);
    pix_in_valid = 1'b0;
    check("R8 next beat after release", {8'h0, pix_out_rgb}, 32'h440000);
    look("R2 stall-time write landed", 8'h05, 24'h992233);

    // R9: same-cycle colour write and lookup of one entry
    wr(12'h000, 32'h14000000);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h5A000000;
    pix_in_valid = 1'b1; pix_in_index = 8'h14;
    @(negedge clk);
    reg_wr_en = 1'b0; pix_in_valid = 1'b0;
    check("R9 clash returns old", {8'h0, pix_out_rgb}, 32'h000000);
    look("R9 later lookup new", 8'h14, 24'h5A0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule